// File: doc/BRIEF.md
# Hybrid-Form FIR Filter with Dynamic Compensation Correction

This block is a small FIR filter for five-level symbols (-2 to +2). It is built in hybrid form: the taps are grouped into sections, and the taps of one section are added directly. The section sums then move through a registered chain in which each stage adds one more section. Each tap's product enters the adder as an offset-binary word, meaning its sign bit is inverted. A single constant at the output removes the offset that all taps share. This keeps the adders free of sign-extension logic.

Each section also has a mask that narrows its partial products to the width its coefficients actually need. The bits above that width are then held at zero, so they do not toggle. Narrowing a product lowers its value by a fixed amount. A second chain, with exactly the same registers as the data chain, carries each section's mask value. That chain's result is multiplied by the tap count and added at the output, so the narrowing error cancels in the same cycle as the data it affected. Coefficients and masks are loaded through a simple write port. Adaptation logic is not part of the block.

Top module: `hfir_dyncomp`

## Requirements
- R1: While `rst_n` is low, every coefficient, every mask and the delay line are cleared, and `y_out` reads 0. After reset is released with zero input, `y_out` stays 0.
- R2: `sym_in` is a 3-bit two's-complement symbol limited to -2..+2. Let x(e) be the symbol sampled at rising edge e. After edge m, `y_out` equals the sum over k of h[k]·x(m-2-k), where k runs over the 8 taps. An impulse sampled at edge e therefore first shows up, weighted by h[0], after edge e+2.
- R3: A write happens at a rising edge while `wr_en` is high. Address 0..7 loads coefficient k = address from `wr_data[9:0]` as two's complement; `wr_data[10]` is ignored for coefficients. Address 8..9 loads the mask of section address-8 from all 11 bits. Addresses 10..15 change nothing.
- R4: A section mask is either zero or a run of ones that starts at bit 10 and extends downward without gaps. Let b be the lowest set bit of {1, mask}, where the leading 1 sits at bit 11. Every product h·x in that section must lie in [-2^b, 2^b-1]. Under that condition, `y_out` is exactly the full-precision sum, whatever mask is chosen.
- R5: A mask write acts on the product generators and on the correction chain at the same edge. `y_out` stays exact across mask changes while symbols keep streaming.
- R6: Section s covers taps 4s..4s+3. Its contribution to `y_out` after edge m uses the coefficients as they stood after edge m-2+s. A coefficient written at edge e therefore reaches section 1 one edge before it reaches section 0.
- R7: After 11 consecutive zero symbols, `y_out` is 0, whatever the coefficients and masks are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 3 | Five-level input symbol, two's complement |
| wr_en | input | 1 | Write strobe for coefficient or mask |
| wr_addr | input | 4 | Write target: taps 0..7, masks 8..9 |
| wr_data | input | 11 | Coefficient (low 10 bits) or section mask |
| y_out | output | 16 | Filter output, two's complement |

## Verification
The assertions rely on three conditions at the inputs. Symbols stay within -2..+2. Every mask is a run of ones starting at the top bit. Each section's mask is wide enough for twice the largest coefficient magnitude in that section. The bench meets these conditions by drawing symbols from the five legal values. It computes each mask from the coefficient magnitudes. When it loads new coefficients, it first widens the mask to cover both the old and the new set, writes the coefficients, and only then tightens the mask. As a result, every register state the pipelines can capture is valid.

// File: rtl/hfir_pkg.sv
package hfir_pkg;

    // Destination selected by the write port address.
    typedef enum logic [1:0] {
        WT_NONE,
        WT_COEF,
        WT_MASK
    } wr_tgt_e;

endpackage

// File: rtl/hfir_ppgen.sv
// One tap: symbol times coefficient, emitted in offset-binary form and
// narrowed to the section's reduced width.
module hfir_ppgen #(
    parameter int CW  = 10,
    parameter int SYW = 3,
    parameter int PW  = CW + SYW - 1
) (
    input  logic signed [CW-1:0]  coef,
    input  logic signed [SYW-1:0] sym,
    input  logic        [PW-1:0]  clr,   // bits forced to zero
    input  logic        [PW-1:0]  bnd,   // position of the inverted sign
    output logic        [PW-1:0]  pp
);

    logic signed [PW-1:0] prod;

    assign prod = PW'(coef) * PW'(sym);

    // Keep the bits below the boundary; place the inverted sign at the boundary.
    assign pp = (prod & ~clr) | (prod[PW-1] ? '0 : bnd);

endmodule

// File: rtl/hfir_section.sv
// One hybrid section: direct summation of its taps plus the per-tap
// compensation difference derived from the section mask.
module hfir_section #(
    parameter int T   = 4,
    parameter int CW  = 10,
    parameter int SYW = 3,
    parameter int PW  = CW + SYW - 1,
    parameter int OW  = 16
) (
    input  logic [T-1:0][CW-1:0]  coefs,
    input  logic [T-1:0][SYW-1:0] syms,
    input  logic [PW-2:0]         mask,
    output logic [OW-1:0]         psum,
    output logic [OW-1:0]         corr
);

    logic [PW-1:0] clr;
    logic [PW-1:0] bnd;
    logic [PW-1:0] pp [T];

    assign clr = {1'b1, mask};
    assign bnd = clr & (~clr + PW'(1));

    for (genvar j = 0; j < T; j++) begin : g_tap
        hfir_ppgen #(
            .CW  (CW),
            .SYW (SYW),
            .PW  (PW)
        ) u_pp (
            .coef (coefs[j]),
            .sym  (syms[j]),
            .clr  (clr),
            .bnd  (bnd),
            .pp   (pp[j])
        );
    end

    always_comb begin
        psum = '0;
        for (int j = 0; j < T; j++) begin
            psum = psum + OW'(pp[j]);
        end
    end

    // The narrowing removes a run of ones from each tap's word; this is it.
    assign corr = OW'(mask);

endmodule

// File: rtl/hfir_pipe.sv
// Registered accumulation chain: stage s adds term s to stage s-1.
// Instantiated twice so data and correction share one register structure.
module hfir_pipe #(
    parameter int S        = 2,
    parameter int W        = 16,
    parameter int RST_STEP = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [S-1:0][W-1:0] terms,
    output logic [W-1:0]        acc_out
);

    logic [W-1:0] stg [S];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < S; s++) begin
                stg[s] <= W'((s + 1) * RST_STEP);
            end
        end else begin
            stg[0] <= terms[0];
            for (int s = 1; s < S; s++) begin
                stg[s] <= stg[s-1] + terms[s];
            end
        end
    end

    assign acc_out = stg[S-1];

endmodule

// File: rtl/hfir_dyncomp.sv
module hfir_dyncomp
    import hfir_pkg::*;
#(
    parameter int SECTIONS = 2,
    parameter int TAPS     = 4,
    parameter int CW       = 10,
    parameter int SYW      = 3,
    parameter int OW       = 16,
    parameter int NTAP     = SECTIONS * TAPS,
    parameter int PW       = CW + SYW - 1,
    parameter int MW       = PW - 1,
    parameter int AW       = $clog2(NTAP + SECTIONS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [SYW-1:0] sym_in,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [MW-1:0]         wr_data,
    output logic signed [OW-1:0]  y_out
);

    localparam int DL        = NTAP + SECTIONS - 1;
    localparam int DATA_STEP = TAPS * (1 << (PW - 1));
    localparam logic [OW-1:0] COMP = OW'(-(NTAP * (1 << (PW - 1))));
    localparam logic [OW-1:0] TMUL = OW'(TAPS);
    localparam logic [AW-1:0] A_MSK = AW'(NTAP);
    localparam logic [AW-1:0] A_END = AW'(NTAP + SECTIONS);

    logic [NTAP-1:0][CW-1:0]     coef_q;
    logic [SECTIONS-1:0][MW-1:0] mask_q;
    logic [SYW-1:0]              dly [DL];
    wr_tgt_e                     tgt;

    logic [SECTIONS-1:0][OW-1:0] sec_sum;
    logic [SECTIONS-1:0][OW-1:0] sec_corr;
    logic [OW-1:0]               data_out;
    logic [OW-1:0]               corr_out;

    // Write address decode
    always_comb begin
        if (wr_addr < A_MSK) begin
            tgt = WT_COEF;
        end else if (wr_addr < A_END) begin
            tgt = WT_MASK;
        end else begin
            tgt = WT_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NTAP; i++) begin
                if (tgt == WT_COEF && wr_addr == AW'(i)) begin
                    coef_q[i] <= wr_data[CW-1:0];
                end
            end
            for (int s = 0; s < SECTIONS; s++) begin
                if (tgt == WT_MASK && wr_addr == AW'(NTAP + s)) begin
                    mask_q[s] <= wr_data;
                end
            end
        end
    end

    // Symbol delay line, long enough for the chain offset of later sections
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DL; i++) begin
                dly[i] <= '0;
            end
        end else begin
            dly[0] <= sym_in;
            for (int i = 1; i < DL; i++) begin
                dly[i] <= dly[i-1];
            end
        end
    end

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        logic [TAPS-1:0][SYW-1:0] syms;

        always_comb begin
            for (int j = 0; j < TAPS; j++) begin
                syms[j] = dly[s*TAPS + j + s];
            end
        end

        hfir_section #(
            .T   (TAPS),
            .CW  (CW),
            .SYW (SYW),
            .PW  (PW),
            .OW  (OW)
        ) u_sec (
            .coefs (coef_q[s*TAPS +: TAPS]),
            .syms  (syms),
            .mask  (mask_q[s]),
            .psum  (sec_sum[s]),
            .corr  (sec_corr[s])
        );
    end

    hfir_pipe #(
        .S        (SECTIONS),
        .W        (OW),
        .RST_STEP (DATA_STEP)
    ) u_data_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .terms   (sec_sum),
        .acc_out (data_out)
    );

    hfir_pipe #(
        .S        (SECTIONS),
        .W        (OW),
        .RST_STEP (0)
    ) u_corr_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .terms   (sec_corr),
        .acc_out (corr_out)
    );

    assign y_out = data_out + COMP + corr_out * TMUL;

endmodule

// File: rtl/hfir_dyncomp_chk.sv
module hfir_dyncomp_chk #(
    parameter int SECTIONS = 2,
    parameter int TAPS     = 4,
    parameter int CW       = 10,
    parameter int SYW      = 3,
    parameter int OW       = 16,
    parameter int NTAP     = SECTIONS * TAPS,
    parameter int PW       = CW + SYW - 1,
    parameter int MW       = PW - 1,
    parameter int AW       = $clog2(NTAP + SECTIONS + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic signed [SYW-1:0]       sym_in,
    input logic                        wr_en,
    input logic [AW-1:0]               wr_addr,
    input logic [NTAP-1:0][CW-1:0]     coef_q,
    input logic [SECTIONS-1:0][MW-1:0] mask_q,
    input logic [OW-1:0]               corr_out,
    input logic signed [OW-1:0]        y_out
);

    localparam int ZL = NTAP + SECTIONS - 1 + SECTIONS;
    localparam int ZW = $clog2(ZL + 2);
    localparam int QL = SECTIONS + 1;
    localparam int QW = $clog2(QL + 2);

    logic [ZW-1:0] zc;
    logic [QW-1:0] qc;
    logic          shape_ok;
    logic          fit_ok;
    logic          mask_wr;

    assign mask_wr = wr_en && (wr_addr >= AW'(NTAP)) && (wr_addr < AW'(NTAP + SECTIONS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc <= '0;
            qc <= '0;
        end else begin
            if (sym_in != '0) begin
                zc <= '0;
            end else if (zc != ZW'(ZL)) begin
                zc <= zc + ZW'(1);
            end
            if (mask_wr) begin
                qc <= '0;
            end else if (qc != QW'(QL)) begin
                qc <= qc + QW'(1);
            end
        end
    end

    always_comb begin
        shape_ok = 1'b1;
        for (int s = 0; s < SECTIONS; s++) begin
            logic [MW-1:0] inv;
            inv = ~mask_q[s];
            if ((inv & (inv + MW'(1))) != '0) begin
                shape_ok = 1'b0;
            end
        end
    end

    always_comb begin
        fit_ok = 1'b1;
        for (int s = 0; s < SECTIONS; s++) begin
            logic [PW-1:0] f;
            logic [PW-1:0] lb;
            f  = {1'b1, mask_q[s]};
            lb = f & (~f + PW'(1));
            for (int j = 0; j < TAPS; j++) begin
                int h;
                int a;
                h = int'($signed(coef_q[s*TAPS + j]));
                a = (h < 0) ? -h : h;
                if (2 * a > int'(lb) - 1) begin
                    fit_ok = 1'b0;
                end
            end
        end
    end

    // R2
    sym_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(sym_in) >= -2) && ($signed(sym_in) <= 2));

    // R4
    mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shape_ok);

    // R4
    mask_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_ok);

    // R5
    corr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qc == QW'(QL)) |-> $stable(corr_out));

    // R7
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zc == ZW'(ZL)) |-> (y_out == '0));

endmodule

bind hfir_dyncomp hfir_dyncomp_chk #(
    .SECTIONS (SECTIONS),
    .TAPS     (TAPS),
    .CW       (CW),
    .SYW      (SYW),
    .OW       (OW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sym_in   (sym_in),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .coef_q   (coef_q),
    .mask_q   (mask_q),
    .corr_out (corr_out),
    .y_out    (y_out)
);

// File: tb/hfir_dyncomp_tb.sv
`timescale 1ns/1ps
module hfir_dyncomp_tb;

    localparam int S  = 2;
    localparam int T  = 4;
    localparam int N  = 8;

    logic               clk     = 1'b0;
    logic               rst_n   = 1'b0;
    logic signed [2:0]  sym_in  = '0;
    logic               wr_en   = 1'b0;
    logic [3:0]         wr_addr = '0;
    logic [10:0]        wr_data = '0;
    logic signed [15:0] y_out;

    int checks = 0;
    int fails  = 0;
    int e      = 0;
    int seed   = 7;
    int cap [4096];
    int hs  [4096][8];
    int ch  [8];
    int h0  [8] = '{3, -5, 7, -11, 13, -17, 19, -23};
    int nh  [8];

    always #10 clk = ~clk;

    hfir_dyncomp u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_in  (sym_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .y_out   (y_out)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 32'h7fff;
    endfunction

    function automatic int rsym();
        return (rnd() % 5) - 2;
    endfunction

    // Output after edge m: section s used coefficients held after edge m-2+s.
    function automatic int model(input int m);
        int acc = 0;
        for (int s = 0; s < S; s++) begin
            for (int j = 0; j < T; j++) begin
                int k  = s * T + j;
                int sn = m - S + s;
                int di = m - 2 - k;
                if (sn >= 0 && di >= 0) acc += hs[sn][k] * cap[di];
            end
        end
        return acc;
    endfunction

    // Thermometer mask giving room for products of +-2 times magnitude mx.
    function automatic int mask_for(input int mx);
        int w = 1;
        while (((1 << (w - 1)) - 1) < 2 * mx) w++;
        return 2048 - (1 << (w - 1));
    endfunction

    function automatic int sec_max(input int a [8], input int s);
        int mx = 0;
        for (int j = 0; j < T; j++) begin
            int v = a[s*T + j];
            if (v < 0) v = -v;
            if (v > mx) mx = v;
        end
        return mx;
    endfunction

    task automatic step(input int x, input bit we, input int addr, input int data,
                        input string req);
        sym_in  = 3'(x);
        wr_en   = we;
        wr_addr = 4'(addr);
        wr_data = 11'(data);
        @(posedge clk);
        e++;
        cap[e] = x;
        if (we && addr < N) begin
            int v = data & 'h3FF;
            if (v >= 512) v -= 1024;
            ch[addr] = v;
        end
        for (int k = 0; k < N; k++) hs[e][k] = ch[k];
        @(negedge clk);
        chk(int'(y_out), model(e), req);
        wr_en = 1'b0;
    endtask

    // Widen masks, write coefficients, then tighten masks, all while streaming.
    task automatic load_coefs(input int nv [8], input string req);
        for (int s = 0; s < S; s++) begin
            int mo = sec_max(ch, s);
            int mn = sec_max(nv, s);
            step(rsym(), 1'b1, N + s, mask_for((mo > mn) ? mo : mn), req);
        end
        for (int k = 0; k < N; k++) step(rsym(), 1'b1, k, nv[k] & 'h3FF, req);
        for (int s = 0; s < S; s++) step(rsym(), 1'b1, N + s, mask_for(sec_max(nv, s)), req);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog all-requirements actual=hung expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(y_out), 0, "R1 output during reset");
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) step(0, 1'b0, 0, 0, "R1 idle after reset");

        // R3 coefficient loading, R2 impulse responses
        for (int k = 0; k < N; k++) step(0, 1'b1, k, h0[k] & 'h3FF, "R3 coefficient write");
        step(1, 1'b0, 0, 0, "R2 impulse +1");
        for (int i = 0; i < 11; i++) step(0, 1'b0, 0, 0, "R2 impulse +1 tail");
        step(-2, 1'b0, 0, 0, "R2 impulse -2");
        for (int i = 0; i < 11; i++) step(0, 1'b0, 0, 0, "R2 impulse -2 tail");
        for (int i = 0; i < 60; i++) step(rsym(), 1'b0, 0, 0, "R2 random stream");

        // R3 unmapped addresses and the unused top data bit
        for (int a = 10; a < 16; a++) step(rsym(), 1'b1, a, 'h7FF, "R3 unmapped address ignored");
        for (int i = 0; i < 12; i++) step(rsym(), 1'b0, 0, 0, "R3 stream after unmapped writes");
        step(rsym(), 1'b1, 2, 'h400 | (-9 & 'h3FF), "R3 data bit 10 ignored");
        for (int i = 0; i < 12; i++) step(rsym(), 1'b0, 0, 0, "R3 stream after coefficient write");

        // R4 tight masks on a running stream
        for (int s = 0; s < S; s++) step(rsym(), 1'b1, N + s, mask_for(sec_max(ch, s)), "R4 tight mask write");
        for (int i = 0; i < 40; i++) step(rsym(), 1'b0, 0, 0, "R4 reduced representation");

        // R4/R6 magnitude sweep with coefficient changes mid-stream
        for (int b = 0; b < 10; b++) begin
            int lim = (1 << b) - 1;
            for (int k = 0; k < N; k++) begin
                if (b == 9 && k == 0)      nh[k] = -512;
                else if (b == 9 && k == 5) nh[k] = 511;
                else if (lim == 0)         nh[k] = 0;
                else                       nh[k] = (rnd() % (2 * lim + 1)) - lim;
            end
            load_coefs(nh, "R6 coefficient update mid-stream");
            for (int i = 0; i < 20; i++) step(rsym(), 1'b0, 0, 0, "R4 magnitude sweep");
        end

        // R6 directed: constant input, single-tap change in each section
        for (int i = 0; i < 12; i++) step(1, 1'b0, 0, 0, "R6 steady input");
        step(1, 1'b1, 0, 0, "R6 shrink tap 0");
        for (int i = 0; i < 4; i++) step(1, 1'b0, 0, 0, "R6 tap 0 change reaching output");
        step(1, 1'b1, 4, 0, "R6 shrink tap 4");
        for (int i = 0; i < 4; i++) step(1, 1'b0, 0, 0, "R6 tap 4 change reaching output");

        // R5 toggle masks while streaming
        for (int r = 0; r < 6; r++) begin
            for (int s = 0; s < S; s++) step(rsym(), 1'b1, N + s, 0, "R5 mask loosen");
            for (int i = 0; i < 3; i++) step(rsym(), 1'b0, 0, 0, "R5 after loosen");
            for (int s = 0; s < S; s++) step(rsym(), 1'b1, N + s, mask_for(sec_max(ch, s)), "R5 mask tighten");
            for (int i = 0; i < 3; i++) step(rsym(), 1'b0, 0, 0, "R5 after tighten");
        end

        // R7 zero flush
        for (int i = 0; i < 14; i++) step(0, 1'b0, 0, 0, "R7 zero flush");
        chk(int'(y_out), 0, "R7 output zero after flush");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule